// File: doc/BRIEF.md
# Triangle-Wave Frequency Dither Generator

This block makes the digital modulation code for a spread-spectrum clock. On every master-clock cycle it presents an offset word. A downstream numerically controlled or fractional clock generator subtracts that word from its nominal increment. The offset follows a symmetric triangle that rises from zero to a selectable peak and falls back again. The clock therefore only ever slows down. Its frequency is never pushed above the undithered value.

One triangle sweep lasts 2^PHASE_W master cycles, which is 4096 by default, so the modulation rate is the master frequency divided by 4096. The offset is read against a reference count of 50 * 2^(PHASE_W-1), which is 102400 by default. A peak of 2048 is therefore a 2% reduction and a peak of 4096 is a 4% reduction. A single select bit picks the depth, and a new value is taken only at the bottom of the triangle. While the enable input is low the offset is zero and the sweep is re-armed, so every enable starts from the bottom.

Top module: `tri_dither_gen`

## Requirements
- R1: With the enable held high, the offset word returns to zero exactly once every 4096 cycles.
- R2: Let k be the number of enabled rising edges since the last zero, taken modulo 4096. The triangle index is k for k up to 2048 and 4096-k above that. Zero and the peak each occur once per sweep.
- R3: A rising edge with the enable low sets the offset to zero, and the offset stays zero while the enable remains low.
- R4: Depth encoding: with the select at 1, offset = index (peak 2048, 2% of 102400). With the select at 0, offset = 2 * index (peak 4096, 4%).
- R5: The depth select is sampled only while the triangle sits at zero (enable low, or index 0). A change in mid-sweep has no effect until the next zero.
- R6: The first enabled edge after any disabled period gives the smallest step: 1 at 2% depth, 2 at 4% depth.
- R7: The offset never exceeds 4096, and two consecutive enabled values differ by at most 2.
- R8: During and right after reset the offset is zero and the depth is 2%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| spreadEn | input | 1 | Dither enable; low holds the offset at zero and re-arms the sweep |
| sel2pct | input | 1 | Depth select: 1 = 2% peak, 0 = 4% peak |
| offsetWord | output | PHASE_W+1 | Fractional frequency reduction relative to 50*2^(PHASE_W-1) |

## Verification
A wrong phase count or a wrong turn-around point shifts where the peak and the zero fall. This shows as a wrong offset value within one cycle of the bad step, and the error persists for the rest of the sweep. A stale or early depth latch changes the step size at once, either mid-sweep or on the first enabled edge. A missing clear on disable shows as a nonzero offset one edge after the enable falls. The bench compares every cycle against a sweep model, so each of these faults is reported in the cycle it first appears.

// File: rtl/dither_pkg.sv
package dither_pkg;
  // Strobes from the sweep control to the triangle datapath
  typedef struct packed {
    logic clear;      // force triangle to its minimum
    logic step;       // advance triangle by one position
    logic falling;    // current half-sweep is descending
    logic loadDepth;  // triangle at minimum: depth select may be taken
  } ditherStrobes_t;
endpackage

// File: rtl/dither_ctrl.sv
module dither_ctrl
  import dither_pkg::*;
#(
  parameter int PHASE_W = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           spreadEn,
  output ditherStrobes_t strobes
);
  logic [PHASE_W-1:0] phaseQ;
  logic               atMin;

  // phase wraps naturally at 2^PHASE_W, giving the sweep period
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (!spreadEn) begin
      phaseQ <= '0;
    end else begin
      phaseQ <= phaseQ + 1'b1;
    end
  end

  assign atMin = (phaseQ == '0);

  always_comb begin
    strobes.clear     = !spreadEn;
    strobes.step      = spreadEn;
    // upper half of the phase space walks the triangle back down
    strobes.falling   = phaseQ[PHASE_W-1];
    strobes.loadDepth = !spreadEn || atMin;
  end
endmodule

// File: rtl/dither_dp.sv
module dither_dp
  import dither_pkg::*;
#(
  parameter int PHASE_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sel2pct,
  input  ditherStrobes_t   strobes,
  output logic [PHASE_W:0] offsetWord
);
  logic [PHASE_W-1:0] triQ;
  logic               wideQ;  // 1 selects the doubled (4%) depth

  always_ff @(posedge clk) begin
    if (!rstN) begin
      triQ <= '0;
    end else if (strobes.clear) begin
      triQ <= '0;
    end else if (strobes.step) begin
      if (strobes.falling) triQ <= triQ - 1'b1;
      else                 triQ <= triQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wideQ <= 1'b0;
    end else if (strobes.loadDepth) begin
      wideQ <= !sel2pct;
    end
  end

  assign offsetWord = wideQ ? {triQ, 1'b0} : {1'b0, triQ};
endmodule

// File: rtl/tri_dither_gen.sv
module tri_dither_gen
  import dither_pkg::*;
#(
  parameter int PHASE_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             spreadEn,
  input  logic             sel2pct,
  output logic [PHASE_W:0] offsetWord
);
  ditherStrobes_t strobes;

  dither_ctrl #(.PHASE_W(PHASE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .spreadEn (spreadEn),
    .strobes  (strobes)
  );

  dither_dp #(.PHASE_W(PHASE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sel2pct    (sel2pct),
    .strobes    (strobes),
    .offsetWord (offsetWord)
  );
endmodule

// File: rtl/tri_dither_chk.sv
module tri_dither_chk #(
  parameter int PHASE_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             spreadEn,
  input logic             sel2pct,
  input logic [PHASE_W:0] offsetWord
);
  localparam int PEAK = 1 << PHASE_W;

  // R7: offset stays within the 4% peak
  a_r7_peak_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(offsetWord) <= PEAK);

  // R3: a disabled edge zeroes the offset
  a_r3_disable_zero: assert property (@(posedge clk) disable iff (!rstN)
    !spreadEn |=> offsetWord == '0);

  // R6: the first enabled edge yields the smallest step
  a_r6_restart_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spreadEn) |=> (int'(offsetWord) == 1 || int'(offsetWord) == 2));

  // R7: consecutive enabled values move by at most two
  a_r7_step_small: assert property (@(posedge clk) disable iff (!rstN)
    $past(spreadEn) |-> (int'(offsetWord) <= int'($past(offsetWord)) + 2 &&
                         int'(offsetWord) + 2 >= int'($past(offsetWord))));
endmodule

bind tri_dither_gen tri_dither_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .spreadEn   (spreadEn),
  .sel2pct    (sel2pct),
  .offsetWord (offsetWord)
);

// File: tb/tri_dither_gen_tb.sv
`timescale 1ns/1ps
module tri_dither_gen_tb;
  localparam int PHASE_W = 12;
  localparam int SWEEP   = 1 << PHASE_W;
  localparam int HALF    = SWEEP / 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             spreadEn = 1'b0;
  logic             sel2pct = 1'b1;
  logic [PHASE_W:0] offsetWord;

  int checks = 0;
  int fails  = 0;
  int mPhase = 0;
  bit mNarrow = 1'b1;
  string curTag = "R8";

  always #5 clk = ~clk;

  tri_dither_gen #(.PHASE_W(PHASE_W)) u_dut (
    .clk(clk), .rstN(rstN), .spreadEn(spreadEn), .sel2pct(sel2pct),
    .offsetWord(offsetWord)
  );

  function automatic int triIndex(int p);
    return (p <= HALF) ? p : SWEEP - p;
  endfunction

  function automatic int expOffset(int p, bit narrow);
    return triIndex(p) * (narrow ? 1 : 2);
  endfunction

  // sweep model from the requirements (inputs are stable at posedge)
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mNarrow = 1'b1;
    end else if (!spreadEn) begin
      mPhase = 0; mNarrow = sel2pct;
    end else begin
      if (mPhase == 0) mNarrow = sel2pct;
      mPhase = (mPhase + 1) % SWEEP;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: offset actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(spreadEn ? curTag : "R3", int'(offsetWord), expOffset(mPhase, mNarrow));
    end
  endtask

  initial begin
    int v;
    void'($urandom(32'd7321));
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8", int'(offsetWord), 0);
    rstN = 1'b1;
    cyc(2);
    chk("R8", int'(offsetWord), 0);

    // R2/R4/R1/R6: one full sweep at 2%
    curTag = "R2";
    sel2pct = 1'b1; spreadEn = 1'b1;
    cyc(1);           chk("R6", int'(offsetWord), 1);
    cyc(HALF - 1);    chk("R4", int'(offsetWord), HALF);
    cyc(1);           chk("R2", int'(offsetWord), HALF - 1);
    cyc(HALF - 1);    chk("R1", int'(offsetWord), 0);
    cyc(1);           chk("R2", int'(offsetWord), 1);

    // R5: mid-sweep select change waits for the minimum
    cyc(500);
    curTag = "R5";
    sel2pct = 1'b0;
    v = int'(offsetWord);
    cyc(1);           chk("R5", int'(offsetWord), v + 1);
    for (int i = 0; i < SWEEP && offsetWord != '0; i++) cyc(1);
    chk("R1", int'(offsetWord), 0);
    curTag = "R4";
    cyc(1);           chk("R4", int'(offsetWord), 2);
    cyc(HALF - 1);    chk("R4", int'(offsetWord), 2 * HALF);

    // R3 then R6: disable clears, re-enable restarts at the bottom
    spreadEn = 1'b0;
    cyc(1);           chk("R3", int'(offsetWord), 0);
    sel2pct = 1'b1;
    cyc(5);           chk("R3", int'(offsetWord), 0);
    sel2pct = 1'b0; spreadEn = 1'b1;
    cyc(1);           chk("R6", int'(offsetWord), 2);

    // R7: random enable/depth segments against the model
    curTag = "R7";
    for (int s = 0; s < 60; s++) begin
      spreadEn = ($urandom_range(0, 3) != 0);
      sel2pct  = $urandom_range(0, 1);
      cyc($urandom_range(1, 2500));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_900_000;
    checks++;
    fails++;
    $display("FAIL R7: watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule